// File: doc/BRIEF.md
# Constant Complex Bit-Serial Multiplier

This block multiplies a stream of complex samples by one fixed complex coefficient. Each sample arrives as two bit-serial two's-complement words, real and imaginary, least significant bit first and N bits long. The coefficient is fixed at elaboration time. Its real and imaginary parts are each written as M canonic signed digits (values −1, 0, +1, with no two adjacent digits nonzero). The real and imaginary products leave the block as two serial two's-complement words, 2N bits long, least significant bit first. A typical use is a hardwired twiddle-factor rotation inside a serial transform datapath.

The multiplier is one shared array with one cell per digit position. Each cell is built from the coefficient digit pair at its position. If both digits are nonzero it has two full adders in each output row. If exactly one digit is nonzero it has one adder per row. If both digits are zero it holds only the delay flop of the sum chain. Negative digits and the sign bit of the input are handled by inverting input bits. The constant that this inversion leaves behind is added back in two parts. The low-order part is loaded as carry presets in the first cycle of a word. The high-order part, which is the same for both rows, is fed serially into the leftmost cell.

A word occupies 2N cycles: N data cycles followed by N gap cycles, and a new word may start right after the gap. The parameters must satisfy N_BITS > M_DIGITS, so that the full product fits in 2N bits.

Top module: `cplx_const_mult`

## Requirements
- R1: Over the 2N output cycles of a word, `mr_bit` carries Ar·Xr − Ai·Xi as a 2N-bit two's-complement number, least significant bit first.
- R2: Over the same cycles, `mi_bit` carries Ar·Xi + Ai·Xr as a 2N-bit two's-complement number, least significant bit first.
- R3: `word_start` is high in the cycle that presents input bit 0. Product bit t is on `mr_bit`/`mi_bit` in cycle t+1 of the word. `m_lsb` is high in cycle 1 of every word and low in the other cycles of that word.
- R4: Input bits in cycles N to 2N−1 of a word (the gap) are ignored: any values there leave both products unchanged.
- R5: A word may start exactly 2N cycles after the previous start, or at any later time. Each result depends only on its own input word.
- R6: Products are exact across the whole input range, including −2^(N−1) on either input or on both inputs.
- R7: After reset and before the first `word_start`, `mr_bit`, `mi_bit` and `m_lsb` stay at 0.
- R8: Digit k of a coefficient sits at bits [2k+1:2k] of COEF_RE or COEF_IM, coded as 00 = 0, 01 = +1, 11 = −1 (10 acts as 0). Any valid digit pair is handled, including positions where both digits are nonzero with equal or opposite signs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| word_start | input | 1 | High in the cycle of input bit 0 of a word |
| xr_bit | input | 1 | Serial real part of the input, LSB first |
| xi_bit | input | 1 | Serial imaginary part of the input, LSB first |
| mr_bit | output | 1 | Serial real part of the product, LSB first |
| mi_bit | output | 1 | Serial imaginary part of the product, LSB first |
| m_lsb | output | 1 | High while product bit 0 is on the outputs |

## Verification
The most negative input on one or both parts is the main target. If the sign-bit inversion or the high-order constant were wrong, these products would come out off by a power of two or with the wrong sign. Gap cycles are driven with random bits. A missing data gate would add those bits into the upper half of the product. Words are sent back to back, and also with idle cycles between them. Sums or carries left over from the previous word would then corrupt the low bits of the next result. A second coefficient places both digits nonzero, with opposite signs, at several positions. This catches a real-row inversion rule applied with the wrong polarity, or a missing second carry preset in a dual cell.

// File: rtl/ccm_pkg.sv
`timescale 1ns/1ps
package ccm_pkg;

    // Two-bit signed-digit code used by COEF_RE / COEF_IM
    typedef enum logic [1:0] {
        DIG_ZERO  = 2'b00,
        DIG_PLUS  = 2'b01,
        DIG_RSV   = 2'b10,
        DIG_MINUS = 2'b11
    } csd_digit_e;

    // Per-cycle control broadcast to every cell of both rows
    typedef struct packed {
        logic first;    // cycle of input bit 0: preset carries, cut sum chain
        logic data_en;  // input bit belongs to the data part of the word
        logic msb;      // input bit is the sign bit
        logic hi_bit;   // serial bit of the shared high-order constant
    } seq_ctl_t;

    typedef struct packed {
        logic c;
        logic s;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic a, input logic b, input logic ci);
        fa_out_t r;
        r.s = a ^ b ^ ci;
        r.c = (a & b) | (a & ci) | (b & ci);
        return r;
    endfunction

    function automatic logic dig_positive(input logic [1:0] code);
        return code == DIG_PLUS;
    endfunction

    function automatic logic dig_negative(input logic [1:0] code);
        return code == DIG_MINUS;
    endfunction

    function automatic logic dig_nonzero(input logic [1:0] code);
        return (code == DIG_PLUS) || (code == DIG_MINUS);
    endfunction

endpackage

// File: rtl/ccm_seq.sv
`timescale 1ns/1ps
module ccm_seq
    import ccm_pkg::*;
#(
    parameter int N_BITS   = 8,
    parameter int M_DIGITS = 6,
    parameter logic [2*N_BITS-1:0] HI_CONST = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     word_start,
    output seq_ctl_t ctl
);
    localparam int FRAME = 2 * N_BITS;
    localparam int PW    = $clog2(FRAME + 1);
    localparam int SW    = $clog2(FRAME + M_DIGITS + 1);

    logic [PW-1:0]    cnt_q;
    logic [PW-1:0]    phase;
    logic [SW-1:0]    shamt;
    logic [FRAME-1:0] hi_sh;
    logic             unused_hi;

    // phase = position inside the current word; FRAME means idle
    assign phase = word_start ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= PW'(FRAME);
        end else if (phase == PW'(FRAME)) begin
            cnt_q <= phase;
        end else begin
            cnt_q <= phase + 1'b1;
        end
    end

    // the leftmost cell at phase t adds weight t + M - 1
    assign shamt     = SW'(phase) + SW'(M_DIGITS - 1);
    assign hi_sh     = HI_CONST >> shamt;
    assign unused_hi = ^hi_sh[FRAME-1:1];

    always_comb begin
        ctl.first   = word_start;
        ctl.data_en = phase < PW'(N_BITS);
        ctl.msb     = phase == PW'(N_BITS - 1);
        ctl.hi_bit  = hi_sh[0];
    end

endmodule

// File: rtl/ccm_cell.sv
`timescale 1ns/1ps
module ccm_cell
    import ccm_pkg::*;
#(
    parameter bit USE_A = 1'b0,
    parameter bit NEG_A = 1'b0,
    parameter bit USE_B = 1'b0,
    parameter bit NEG_B = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  seq_ctl_t ctl,
    input  logic     s_in,
    input  logic     x_a,
    input  logic     x_b,
    output logic     s_d,
    output logic     s_q
);
    logic t_a;
    logic t_b;
    logic unused_ctl;

    // Term bits: magnitude pattern with the sign bit flipped for a
    // positive term, all but the sign bit flipped for a negative one.
    assign t_a = ctl.data_en & (x_a ^ NEG_A ^ ctl.msb);
    assign t_b = ctl.data_en & (x_b ^ NEG_B ^ ctl.msb);
    assign unused_ctl = ctl.hi_bit;

    generate
        if (USE_A && USE_B) begin : g_dual
            logic    ca_q;
            logic    cb_q;
            fa_out_t fa_hi;
            fa_out_t fa_lo;
            always_comb begin
                fa_hi = full_add(s_in, t_a, ctl.first ? NEG_A : ca_q);
                fa_lo = full_add(fa_hi.s, t_b, ctl.first ? NEG_B : cb_q);
            end
            assign s_d = fa_lo.s;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ca_q <= 1'b0;
                    cb_q <= 1'b0;
                end else begin
                    ca_q <= fa_hi.c;
                    cb_q <= fa_lo.c;
                end
            end
        end else if (USE_A || USE_B) begin : g_single
            logic    c_q;
            logic    t_sel;
            logic    pre;
            logic    unused_term;
            fa_out_t fa1;
            assign t_sel       = USE_A ? t_a : t_b;
            assign pre         = USE_A ? NEG_A : NEG_B;
            assign unused_term = USE_A ? t_b : t_a;
            always_comb fa1 = full_add(s_in, t_sel, ctl.first ? pre : c_q);
            assign s_d = fa1.s;
            always_ff @(posedge clk) begin
                if (rst) c_q <= 1'b0;
                else     c_q <= fa1.c;
            end
        end else begin : g_empty
            logic unused_terms;
            assign unused_terms = t_a ^ t_b ^ ctl.first;
            assign s_d = s_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b0;
        else     s_q <= s_d;
    end

endmodule

// File: rtl/ccm_row.sv
`timescale 1ns/1ps
module ccm_row
    import ccm_pkg::*;
#(
    parameter int M_DIGITS = 6,
    parameter bit IMAG_ROW = 1'b0,
    parameter logic [2*M_DIGITS-1:0] COEF_RE = '0,
    parameter logic [2*M_DIGITS-1:0] COEF_IM = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  seq_ctl_t ctl,
    input  logic     xr_bit,
    input  logic     xi_bit,
    output logic     y_bit
);
    logic [M_DIGITS-1:0] s_in;
    logic [M_DIGITS-1:0] s_d;
    logic [M_DIGITS-1:0] s_q;
    logic                x_a;
    logic                x_b;
    logic                unused_row;

    // slot A takes the real coefficient digit, slot B the imaginary one
    assign x_a = IMAG_ROW ? xi_bit : xr_bit;
    assign x_b = IMAG_ROW ? xr_bit : xi_bit;

    for (genvar k = 0; k < M_DIGITS; k++) begin : g_cell
        localparam logic [1:0] DA = COEF_RE[2*k +: 2];
        localparam logic [1:0] DB = COEF_IM[2*k +: 2];
        localparam bit UA = dig_nonzero(DA);
        localparam bit UB = dig_nonzero(DB);
        localparam bit NA = dig_negative(DA);
        // real row subtracts Ai*Xi, so its slot B sign is flipped
        localparam bit NB = IMAG_ROW ? dig_negative(DB) : dig_positive(DB);

        if (k == M_DIGITS - 1) begin : g_left
            assign s_in[k] = ctl.hi_bit;
        end else begin : g_chain
            assign s_in[k] = s_q[k+1] & ~ctl.first;
        end

        ccm_cell #(
            .USE_A(UA),
            .NEG_A(NA),
            .USE_B(UB),
            .NEG_B(NB)
        ) u_cell (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl),
            .s_in (s_in[k]),
            .x_a  (x_a),
            .x_b  (x_b),
            .s_d  (s_d[k]),
            .s_q  (s_q[k])
        );
    end

    assign unused_row = ^{s_q[0], s_d[M_DIGITS-1:1]};

    always_ff @(posedge clk) begin
        if (rst) y_bit <= 1'b0;
        else     y_bit <= s_d[0];
    end

endmodule

// File: rtl/cplx_const_mult.sv
`timescale 1ns/1ps
module cplx_const_mult
    import ccm_pkg::*;
#(
    parameter int N_BITS   = 8,
    parameter int M_DIGITS = 6,
    parameter logic [2*M_DIGITS-1:0] COEF_RE = 12'b00_01_00_01_00_11,
    parameter logic [2*M_DIGITS-1:0] COEF_IM = 12'b11_00_00_11_00_00
) (
    input  logic clk,
    input  logic rst,
    input  logic word_start,
    input  logic xr_bit,
    input  logic xi_bit,
    output logic mr_bit,
    output logic mi_bit,
    output logic m_lsb
);
    localparam int FRAME = 2 * N_BITS;

    // Each nonzero digit at position k leaves -2^(N-1+k) behind;
    // both rows hold the same set of terms, so one constant serves both.
    function automatic logic [FRAME-1:0] hi_const();
        logic [FRAME-1:0] acc;
        logic [FRAME-1:0] one;
        acc = '0;
        one = 1;
        for (int k = 0; k < M_DIGITS; k++) begin
            if (dig_nonzero(COEF_RE[2*k +: 2])) acc = acc - (one << (N_BITS - 1 + k));
            if (dig_nonzero(COEF_IM[2*k +: 2])) acc = acc - (one << (N_BITS - 1 + k));
        end
        return acc;
    endfunction

    localparam logic [FRAME-1:0] HI_CONST = hi_const();

    seq_ctl_t seq_ctl;

    ccm_seq #(
        .N_BITS   (N_BITS),
        .M_DIGITS (M_DIGITS),
        .HI_CONST (HI_CONST)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .word_start (word_start),
        .ctl        (seq_ctl)
    );

    ccm_row #(
        .M_DIGITS (M_DIGITS),
        .IMAG_ROW (1'b0),
        .COEF_RE  (COEF_RE),
        .COEF_IM  (COEF_IM)
    ) u_real (
        .clk    (clk),
        .rst    (rst),
        .ctl    (seq_ctl),
        .xr_bit (xr_bit),
        .xi_bit (xi_bit),
        .y_bit  (mr_bit)
    );

    ccm_row #(
        .M_DIGITS (M_DIGITS),
        .IMAG_ROW (1'b1),
        .COEF_RE  (COEF_RE),
        .COEF_IM  (COEF_IM)
    ) u_imag (
        .clk    (clk),
        .rst    (rst),
        .ctl    (seq_ctl),
        .xr_bit (xr_bit),
        .xi_bit (xi_bit),
        .y_bit  (mi_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) m_lsb <= 1'b0;
        else     m_lsb <= word_start;
    end

endmodule

// File: rtl/ccm_checker.sv
`timescale 1ns/1ps
module ccm_checker #(
    parameter int N_BITS = 8
) (
    input logic clk,
    input logic rst,
    input logic word_start,
    input logic m_lsb,
    input logic mr_bit,
    input logic mi_bit,
    input logic data_en,
    input logic msb
);
    localparam int FRAME = 2 * N_BITS;
    localparam int CW    = $clog2(FRAME + 1);

    logic [CW-1:0] since_q;
    logic [CW-1:0] since_now;
    logic          seen_q;

    assign since_now = word_start ? '0 : since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= CW'(FRAME);
            seen_q  <= 1'b0;
        end else begin
            since_q <= (since_now == CW'(FRAME)) ? since_now : since_now + 1'b1;
            if (word_start) seen_q <= 1'b1;
        end
    end

    p_lsb_follows_start_r3: assert property (@(posedge clk) disable iff (rst)
        word_start |=> m_lsb);

    p_lsb_has_cause_r3: assert property (@(posedge clk) disable iff (rst)
        m_lsb |-> $past(word_start));

    p_sign_slot_r4: assert property (@(posedge clk) disable iff (rst)
        msb |-> (since_now == CW'(N_BITS - 1)));

    p_data_window_r4: assert property (@(posedge clk) disable iff (rst)
        data_en |-> (since_now < CW'(N_BITS)));

    p_start_spacing_r5: assert property (@(posedge clk) disable iff (rst)
        word_start |-> (since_q == CW'(FRAME)));

    p_quiet_before_start_r7: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> (!mr_bit && !mi_bit && !m_lsb));

endmodule

bind cplx_const_mult ccm_checker #(
    .N_BITS (N_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_start (word_start),
    .m_lsb      (m_lsb),
    .mr_bit     (mr_bit),
    .mi_bit     (mi_bit),
    .data_en    (seq_ctl.data_en),
    .msb        (seq_ctl.msb)
);

// File: tb/sim_cplx_const_mult.sv
`timescale 1ns/1ps
module sim_cplx_const_mult;
    localparam int N     = 8;
    localparam int FRAME = 2 * N;

    // R8 codes: 00 = 0, 01 = +1, 11 = -1, digit k at bits [2k+1:2k]
    // u0: Ar digits k5..k0 = 0,+1,0,+1,0,-1 -> 19 ; Ai = -1,0,0,-1,0,0 -> -36
    localparam int AR0 = 19;
    localparam int AI0 = -36;
    // u1: Ar = +1,0,-1,0,0,+1 -> 25 ; Ai = -1,0,+1,0,0,-1 -> -25
    localparam int AR1 = 25;
    localparam int AI1 = -25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_start = 1'b0;
    logic xr_bit = 1'b0;
    logic xi_bit = 1'b0;
    logic mr0, mi0, lsb0, mr1, mi1, lsb1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cplx_const_mult u0 (
        .clk(clk), .rst(rst), .word_start(word_start),
        .xr_bit(xr_bit), .xi_bit(xi_bit),
        .mr_bit(mr0), .mi_bit(mi0), .m_lsb(lsb0)
    );

    cplx_const_mult #(
        .N_BITS(8), .M_DIGITS(6),
        .COEF_RE(12'b01_00_11_00_00_01),
        .COEF_IM(12'b11_00_01_00_00_11)
    ) u1 (
        .clk(clk), .rst(rst), .word_start(word_start),
        .xr_bit(xr_bit), .xi_bit(xi_bit),
        .mr_bit(mr1), .mi_bit(mi1), .m_lsb(lsb1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Sends one word and checks both instances against the integer products.
    task automatic send_word(input int xr, input int xi, input bit noisy_gap, input string req);
        logic [N-1:0]     xr_v, xi_v;
        logic [FRAME-1:0] r0, i0, r1, i1;
        logic             l0, l1;
        xr_v = N'(xr);
        xi_v = N'(xi);
        l0 = 1'b0;
        l1 = 1'b1;
        for (int t = 0; t < FRAME; t++) begin
            @(negedge clk);
            word_start = (t == 0);
            if (t < N) begin
                xr_bit = xr_v[t];
                xi_bit = xi_v[t];
            end else begin
                xr_bit = noisy_gap ? 1'($urandom) : 1'b0;
                xi_bit = noisy_gap ? 1'($urandom) : 1'b0;
            end
            @(posedge clk);
            #1;
            r0[t] = mr0; i0[t] = mi0; r1[t] = mr1; i1[t] = mi1;
            if (t == 0) l0 = lsb0;
            if (t == 1) l1 = lsb0;
        end
        check(l0 == 1'b1, "R3", "m_lsb in cycle 1", int'(l0), 1);
        check(l1 == 1'b0, "R3", "m_lsb in cycle 2", int'(l1), 0);
        check(int'($signed(r0)) == AR0*xr - AI0*xi, {"R1 ", req}, $sformatf("u0 real x=(%0d,%0d)", xr, xi),
              int'($signed(r0)), AR0*xr - AI0*xi);
        check(int'($signed(i0)) == AR0*xi + AI0*xr, {"R2 ", req}, $sformatf("u0 imag x=(%0d,%0d)", xr, xi),
              int'($signed(i0)), AR0*xi + AI0*xr);
        check(int'($signed(r1)) == AR1*xr - AI1*xi, {"R8 R1 ", req}, $sformatf("u1 real x=(%0d,%0d)", xr, xi),
              int'($signed(r1)), AR1*xr - AI1*xi);
        check(int'($signed(i1)) == AR1*xi + AI1*xr, {"R8 R2 ", req}, $sformatf("u1 imag x=(%0d,%0d)", xr, xi),
              int'($signed(i1)), AR1*xi + AI1*xr);
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            word_start = 1'b0;
            xr_bit = 1'b0;
            xi_bit = 1'b0;
        end
    endtask

    function automatic int rnd8();
        logic [7:0] v;
        v = 8'($urandom);
        return int'($signed(v));
    endfunction

    // R7: reset state and quiet outputs before the first word
    task automatic test_reset_quiet();
        for (int c = 0; c < 6; c++) begin
            @(posedge clk);
            #1;
            check({mr0, mi0, lsb0, mr1, mi1, lsb1} == 6'b0, "R7", "outputs before first word",
                  int'({mr0, mi0, lsb0, mr1, mi1, lsb1}), 0);
        end
    endtask

    // R1 R2 R3: distinct basic patterns
    task automatic test_basic();
        send_word(1, 0, 1'b0, "unit real");
        send_word(0, 1, 1'b0, "unit imag");
        send_word(5, -3, 1'b0, "mixed");
        send_word(-7, 12, 1'b0, "mixed2");
        send_word(-1, -1, 1'b0, "minus one");
    endtask

    // R6: range limits
    task automatic test_extremes();
        send_word(-128, -128, 1'b0, "R6 both min");
        send_word(-128, 0, 1'b0, "R6 real min");
        send_word(0, -128, 1'b0, "R6 imag min");
        send_word(127, -128, 1'b0, "R6 max/min");
        send_word(127, 127, 1'b0, "R6 both max");
        send_word(0, 0, 1'b0, "R6 zero");
    endtask

    // R4: gap bits driven with noise must not change results
    task automatic test_gap_noise();
        send_word(-128, 127, 1'b1, "R4 gap noise");
        for (int w = 0; w < 8; w++) send_word(rnd8(), rnd8(), 1'b1, "R4 gap noise rnd");
    endtask

    // R5: back-to-back stream, then words separated by idle cycles
    task automatic test_streams();
        for (int w = 0; w < 12; w++) send_word(rnd8(), rnd8(), 1'b0, "R5 back to back");
        for (int w = 0; w < 4; w++) begin
            idle(3 + w * 5);
            send_word(rnd8(), rnd8(), 1'b0, "R5 after idle");
        end
        idle(2);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R5: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset_quiet();
        test_basic();
        test_extremes();
        test_gap_noise();
        test_streams();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule